// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block sits at the front of a single in-order pipeline that is shared by several hardware thread contexts. Each context has its own program counter and register state held elsewhere. In every clock cycle the block names the context that may issue, says whether an issue happens at all, and asks the pipeline to flush when the running context is replaced.

A one-bit policy input chooses between two ways of sharing the pipeline. In interleaved (fine) mode the issuing context may change every cycle. The block walks the contexts in rotation and passes over any that report a stall, so hazards of any length are hidden behind work from other contexts. In blocking (coarse) mode one context keeps the pipeline until it reports an expensive long stall, such as a second-level cache miss. Only then does the block hand the pipeline to another ready context. Short stalls in this mode just idle the pipeline. A hand-over costs one flush cycle plus a fixed number of refill cycles in which nothing issues.

The per-context ready flags and the short and long stall indications are inputs. All three outputs are combinational from these inputs and a small amount of registered state: the rotation pointer and the refill counter.

Top module: `thread_issue_sel`

## Requirements
- R1: After reset the rotation pointer names the highest-numbered context. With no context ready, `issue_vld` and `flush_req` are 0 and `sel_tid` shows that pointer. The first fine-mode issue with all contexts ready goes to context 0.
- R2: In fine mode (`coarse_mode`=0) with at least one bit of `thr_ready` set, `issue_vld` is 1. `sel_tid` is the first ready context found by searching upward, with wrap-around, from the context after the last one issued.
- R3: In fine mode every issue moves the pointer to the issued context. With all contexts ready, the issue order is 0,1,2,…,NTHR-1,0,… so a ready context waits behind the others.
- R4: In fine mode with no context ready, `issue_vld` is 0, `sel_tid` shows the held pointer, and the pointer keeps its value for the next search.
- R5: In fine mode `short_stall` and `long_stall` have no effect on any output, and `flush_req` stays 0.
- R6: In coarse mode, outside refill and with no long stall, `sel_tid` stays on the current context. `issue_vld` is 1 exactly when that context's ready bit is 1 and `short_stall` is 0.
- R7: In coarse mode a `short_stall` drops `issue_vld` for that cycle without a switch or a flush.
- R8: In coarse mode, outside refill, a `long_stall` while some other context is ready raises `flush_req` and holds `issue_vld` low in that cycle. From the next cycle `sel_tid` is the first ready other context after the current one, in rotation order.
- R9: After a switch cycle, `issue_vld` stays 0 for exactly REFILL cycles. In the next cycle the new context issues if it is ready.
- R10: In coarse mode a `long_stall` with no other context ready causes no flush and no switch, and `issue_vld` is 0.
- R11: A `long_stall` during refill causes no second flush and does not change `sel_tid`.
- R12: Returning to fine mode during refill cancels the refill at once: the fine-mode rules of R2 and R4 apply in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coarse_mode | input | 1 | 0 = interleave every cycle, 1 = switch only on long stall |
| thr_ready | input | NTHR | Bit i set when context i is not stalled |
| short_stall | input | 1 | Short hazard on the running context (coarse mode) |
| long_stall | input | 1 | Costly stall on the running context (coarse mode) |
| sel_tid | output | TW | Context chosen this cycle |
| issue_vld | output | 1 | An instruction from `sel_tid` issues this cycle |
| flush_req | output | 1 | Pipeline flush for a context switch |

## Verification
Fine mode is swept over every ready mask from each of the four pointer positions. This separates the wrap-around search from a plain lowest-index priority encoder, and it shows whether the pointer holds or moves when nothing is ready. Coarse mode is swept over every ready mask at each running context with a long stall applied. This separates a real hand-over with its refill window from the no-other-ready case, and it shows whether the running context is wrongly counted as a candidate. Long stalls during refill are checked for a second flush. The stall inputs are toggled in fine mode to confirm they are ignored there, and a mode change during refill is checked for immediate cancellation. A long mixed stream, driven by a linear feedback register, is then compared cycle by cycle against an arithmetic model in the bench.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    localparam int TSEL_THREADS_DEF = 4;
    localparam int TSEL_REFILL_DEF  = 3;

    typedef enum logic {
        POL_FINE   = 1'b0,
        POL_COARSE = 1'b1
    } policy_e;

    typedef enum logic {
        CS_RUN    = 1'b0,
        CS_REFILL = 1'b1
    } cstate_e;

    function automatic int tid_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int cnt_width(input int f);
        return (f > 0) ? $clog2(f + 1) : 1;
    endfunction

    // base < n and 1 <= step <= n
    function automatic int unsigned wrap_add(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned n);
        int unsigned s;
        s = base + step;
        return (s >= n) ? (s - n) : s;
    endfunction

endpackage

// File: rtl/tsel_rr_arb.sv
module tsel_rr_arb #(
    parameter int NTHR = tsel_pkg::TSEL_THREADS_DEF,
    parameter int TW   = tsel_pkg::tid_width(NTHR)
) (
    input  logic [NTHR-1:0] req,
    input  logic [TW-1:0]   last,
    output logic            found,
    output logic [TW-1:0]   pick
);
    logic [TW-1:0]   cand_idx [NTHR];
    logic [NTHR-1:0] cand_hit;

    for (genvar k = 0; k < NTHR; k++) begin : g_off
        assign cand_idx[k] = TW'(tsel_pkg::wrap_add(int'(last), k + 1, NTHR));
        assign cand_hit[k] = req[cand_idx[k]];
    end

    always_comb begin
        pick = last;
        for (int k = NTHR - 1; k >= 0; k--) begin
            if (cand_hit[k]) pick = cand_idx[k];
        end
    end

    assign found = |req;

    always_comb begin
        if (found) begin
            p_pick_is_req_r2: assert (req[pick]);
        end
    end

endmodule

// File: rtl/tsel_coarse_ctl.sv
module tsel_coarse_ctl #(
    parameter int REFILL = tsel_pkg::TSEL_REFILL_DEF,
    parameter int CW     = tsel_pkg::cnt_width(REFILL)
) (
    input  logic clk,
    input  logic rst,
    input  logic coarse_on,
    input  logic long_stall,
    input  logic alt_found,
    output logic switch_now,
    output logic in_refill
);
    import tsel_pkg::*;

    cstate_e       st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    assign in_refill  = coarse_on && (st_q == CS_REFILL);
    assign switch_now = coarse_on && (st_q == CS_RUN) && long_stall && alt_found;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!coarse_on) begin
            st_d  = CS_RUN;
            cnt_d = '0;
        end else if (st_q == CS_RUN) begin
            if (switch_now && REFILL > 0) begin
                st_d  = CS_REFILL;
                cnt_d = CW'(REFILL);
            end
        end else begin
            if (cnt_q <= CW'(1)) begin
                st_d  = CS_RUN;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CS_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(REFILL));

    p_no_reswitch_r11: assert property (@(posedge clk) disable iff (rst)
        switch_now |=> !switch_now);

    p_refill_follows_r9: assert property (@(posedge clk) disable iff (rst)
        (switch_now && coarse_on && REFILL > 0) |=> (in_refill || !coarse_on));

endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel #(
    parameter int NTHR   = tsel_pkg::TSEL_THREADS_DEF,
    parameter int REFILL = tsel_pkg::TSEL_REFILL_DEF,
    localparam int TW    = tsel_pkg::tid_width(NTHR)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            coarse_mode,
    input  logic [NTHR-1:0] thr_ready,
    input  logic            short_stall,
    input  logic            long_stall,
    output logic [TW-1:0]   sel_tid,
    output logic            issue_vld,
    output logic            flush_req
);
    import tsel_pkg::*;

    policy_e         pol;
    logic [TW-1:0]   ptr_q, ptr_d;
    logic [NTHR-1:0] arb_req;
    logic            arb_found;
    logic [TW-1:0]   arb_pick;
    logic            sw_now;
    logic            refill;

    assign pol = policy_e'(coarse_mode);

    always_comb begin
        arb_req = thr_ready;
        if (pol == POL_COARSE) arb_req[ptr_q] = 1'b0;
    end

    tsel_rr_arb #(.NTHR(NTHR), .TW(TW)) u_arb (
        .req   (arb_req),
        .last  (ptr_q),
        .found (arb_found),
        .pick  (arb_pick)
    );

    tsel_coarse_ctl #(.REFILL(REFILL)) u_cctl (
        .clk        (clk),
        .rst        (rst),
        .coarse_on  (coarse_mode),
        .long_stall (long_stall),
        .alt_found  (arb_found),
        .switch_now (sw_now),
        .in_refill  (refill)
    );

    always_comb begin
        ptr_d = ptr_q;
        if (pol == POL_FINE) begin
            issue_vld = arb_found;
            sel_tid   = arb_found ? arb_pick : ptr_q;
            flush_req = 1'b0;
            if (arb_found) ptr_d = arb_pick;
        end else begin
            sel_tid   = ptr_q;
            flush_req = sw_now;
            issue_vld = !refill && thr_ready[ptr_q] && !short_stall && !long_stall;
            if (sw_now) ptr_d = arb_pick;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= TW'(NTHR - 1);
        else     ptr_q <= ptr_d;
    end

    p_fine_no_flush_r5: assert property (@(posedge clk) disable iff (rst)
        !coarse_mode |-> !flush_req);

    p_flush_blocks_issue_r8: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> !issue_vld);

    p_flush_then_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (flush_req && REFILL > 0) |=> (!issue_vld || !coarse_mode));

    p_hold_ptr_r4: assert property (@(posedge clk) disable iff (rst)
        (!coarse_mode && !issue_vld) |=> $stable(ptr_q));

    p_coarse_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (coarse_mode && !flush_req) |=> (!coarse_mode || $stable(sel_tid)));

    p_issue_is_ready_r2: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> thr_ready[sel_tid]);

endmodule

// File: tb/sim_thread_issue_sel.sv
module sim_thread_issue_sel;
    localparam int N  = 4;
    localparam int F  = 3;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          coarse_mode = 1'b0;
    logic [N-1:0]  thr_ready = '0;
    logic          short_stall = 1'b0;
    logic          long_stall = 1'b0;
    logic [TW-1:0] sel_tid;
    logic          issue_vld;
    logic          flush_req;

    int checks = 0;
    int fails  = 0;
    int m_ptr  = N - 1;
    int m_rcnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    thread_issue_sel #(.NTHR(N), .REFILL(F)) u0 (
        .clk(clk), .rst(rst), .coarse_mode(coarse_mode), .thr_ready(thr_ready),
        .short_stall(short_stall), .long_stall(long_stall),
        .sel_tid(sel_tid), .issue_vld(issue_vld), .flush_req(flush_req)
    );

    function automatic int search(input logic [N-1:0] m, input int base, input bit excl);
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (base + k) % N;
            if (m[idx] && !(excl && idx == base)) return idx;
        end
        return -1;
    endfunction

    task automatic step(input logic [N-1:0] rdy, input logic ss, input logic ls,
                        input logic md, input string tag);
        int    e_sel, hit;
        logic  e_vld, e_flush;
        string t;
        @(negedge clk);
        thr_ready = rdy; short_stall = ss; long_stall = ls; coarse_mode = md;
        #1;
        t = tag;
        if (!md) begin
            if (t == "") t = (m_rcnt > 0) ? "R12" : ((ss || ls) ? "R5" : ((rdy != 0) ? "R2" : "R4"));
            hit = search(rdy, m_ptr, 1'b0);
            e_vld = (hit >= 0); e_flush = 1'b0;
            e_sel = (hit >= 0) ? hit : m_ptr;
            if (hit >= 0) m_ptr = hit;
            m_rcnt = 0;
        end else if (m_rcnt > 0) begin
            if (t == "") t = ls ? "R11" : "R9";
            e_vld = 1'b0; e_flush = 1'b0; e_sel = m_ptr;
            m_rcnt--;
        end else begin
            hit = search(rdy, m_ptr, 1'b1);
            e_sel = m_ptr;
            if (ls && hit >= 0) begin
                if (t == "") t = "R8";
                e_vld = 1'b0; e_flush = 1'b1;
                m_ptr = hit; m_rcnt = F;
            end else begin
                if (t == "") t = ls ? "R10" : (ss ? "R7" : "R6");
                e_flush = 1'b0;
                e_vld = rdy[m_ptr] && !ss && !ls;
            end
        end
        checks++;
        if (int'(sel_tid) != e_sel || issue_vld !== e_vld || flush_req !== e_flush) begin
            fails++;
            $display("FAIL %s: sel=%0d vld=%0b flush=%0b expected sel=%0d vld=%0b flush=%0b",
                     t, sel_tid, issue_vld, flush_req, e_sel, e_vld, e_flush);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: idle after reset, then first issue goes to context 0
        step(4'b0000, 0, 0, 0, "R1");
        step(4'b1111, 0, 0, 0, "R1");
        // R3: all ready, strict rotation
        for (int i = 0; i < 8; i++) step(4'b1111, 0, 0, 0, "R3");
        // R2/R4: every mask from every pointer position
        for (int p = 0; p < N; p++)
            for (int m = 0; m < 16; m++) begin
                step(4'(1 << p), 0, 0, 0, "R2");
                step(4'(m), 0, 0, 0, "");
                step(4'(m), 0, 0, 0, "");
            end
        // R5: stall inputs ignored in fine mode
        for (int i = 0; i < 16; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:0], i[0], i[1], 0, "R5");
        end
        // R6..R11: coarse long stall from every context, every mask
        for (int c = 0; c < N; c++)
            for (int m = 0; m < 16; m++) begin
                step(4'(1 << c), 0, 0, 0, "R2");
                step(4'b1111, 0, 0, 1, "R6");
                step(4'(m), 0, 0, 1, "R6");
                step(4'(m), 0, 1, 1, "");
                for (int r = 0; r < F; r++) step(4'b1111, 0, m[0], 1, "");
                step(4'b1111, 0, 0, 1, "R9");
                step(4'b1111, 1, 0, 1, "R7");
            end
        // R12: leave coarse mode during refill
        step(4'b0001, 0, 0, 0, "R2");
        step(4'b1111, 0, 0, 1, "R6");
        step(4'b1111, 0, 1, 1, "R8");
        step(4'b1111, 0, 0, 1, "R9");
        step(4'b1111, 0, 0, 0, "R12");
        step(4'b0000, 0, 0, 0, "R4");
        // mixed stream against the model
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:0], lfsr[4] & lfsr[5], lfsr[6] & lfsr[7], lfsr[9] | lfsr[8], "");
        end
        finish_run();
    end

endmodule